// File: doc/BRIEF.md
# Shadow-Buffered General-Purpose Timer Core

This block is a 16-bit timer core with two counting modes. In single-run mode it counts once to its terminal value and then turns itself off. In repeating mode it reloads at the terminal value and carries on. It counts down from the interval value to zero, or up from zero to the interval value. A comparator raises a match event whenever the running count equals the match value. The interval value and the match value each have a shadow stage. A configuration bit per value selects whether a write takes effect on the next clock edge or waits for the next time-out.

Timers can be chained. When the wait bit is set, an enabled timer stays frozen until the previous timer in the chain pulses `chain_trig_in`. Each time-out, and each enabled match, produces a one-cycle pulse on `chain_trig_o` for the next timer. With the snapshot option in repeating mode, the readable value holds the free-running cycle count captured at the last time-out. Without it, the readable value follows the live count.

Top module: `gp_timer_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs clear to zero and both shadowed values clear to zero.
- R2: With `cfg_mode`=2 (repeating) and `cfg_count_up`=0, the count falls by one per cycle. On the cycle after it is zero it reloads the interval value and `timeout_flag_o` pulses. The period is therefore interval+1 cycles.
- R3: With `cfg_count_up`=1, a start or an interval load sets the count to zero. The count rises to the interval value, then wraps to zero at the time-out.
- R4: With `cfg_mode`=1 (single-run), the time-out clears the internal enable. The count then holds its terminal value and no further time-out follows.
- R5: With `cfg_mode`=0 (reserved) or 3 (capture, not provided), the count neither steps nor times out.
- R6: With `cfg_ivl_defer`=0, an interval write loads the counter at the next edge: the written value when counting down, zero when counting up. With `cfg_ivl_defer`=1, the written value is held and applied at the next time-out reload or the next start.
- R7: With `cfg_match_defer`=0, a match write is active from the next edge. With `cfg_match_defer`=1, it waits for the next time-out, or for the next start if the timer is disabled.
- R8: A match (running count equals active match value) pulses `match_flag_o` and `chain_trig_o` one cycle later only when `cfg_match_ie`=1. Otherwise neither pulses for it.
- R9: `cfg_to_irq_dis`=1 suppresses `timeout_flag_o`, but `chain_trig_o` still pulses at the time-out.
- R10: With `cfg_wait_trig`=1, starting the timer loads the count but freezes it until `chain_trig_in` is seen high at an edge. Counting begins on the edge after that.
- R11: With `cfg_snap_en`=1 in repeating mode, `timer_val_o` shows the count of counting cycles since start, captured at each time-out (zero before the first). Otherwise it equals `count_o`.
- R12: `chain_trig_o` pulses for exactly one cycle after every time-out.
- R13: Writing `en_wd`=0 with `en_we`=1 stops counting at that edge. The count keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | 1 single-run, 2 repeating, 0 and 3 idle |
| cfg_count_up | input | 1 | 1 counts up, 0 counts down |
| cfg_ivl_defer | input | 1 | 1 holds interval writes until time-out or start |
| cfg_match_defer | input | 1 | 1 holds match writes until time-out or start |
| cfg_wait_trig | input | 1 | 1 waits for a chain trigger after start |
| cfg_snap_en | input | 1 | Snapshot of free-running count at time-out |
| cfg_match_ie | input | 1 | Enables match flag and match trigger |
| cfg_to_irq_dis | input | 1 | Suppresses the time-out flag |
| en_we | input | 1 | Enable write strobe |
| en_wd | input | 1 | Enable write value |
| chain_trig_in | input | 1 | Trigger from the previous timer |
| ivl_we | input | 1 | Interval write strobe |
| ivl_wd | input | 16 | Interval write value |
| match_we | input | 1 | Match write strobe |
| match_wd | input | 16 | Match write value |
| count_o | output | 16 | Live count |
| timer_val_o | output | 16 | Readable value (live count or snapshot) |
| timeout_flag_o | output | 1 | One-cycle time-out event |
| match_flag_o | output | 1 | One-cycle match event |
| chain_trig_o | output | 1 | One-cycle trigger to the next timer |

## Verification
The step and hold assertions take for granted that `cfg_count_up` does not change inside a counting period. They also assume that an interval write and a start never land on the same edge in a way that must not load. The stimulus changes direction only under reset or before a start, and it issues every write on its own edge. Mode, interrupt-enable and snapshot bits are changed while running, but only between the edges whose results are checked. That keeps each expected count a direct function of the start edge.

// File: rtl/tmr_pkg.sv
// Shared types for the timer core.
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_OFF      = 2'd0,
        MODE_ONESHOT  = 2'd1,
        MODE_PERIODIC = 2'd2,
        MODE_CAPTURE  = 2'd3
    } tmr_mode_e;
endpackage

// File: rtl/tmr_shadow_reg.sv
// Double-buffered value: a write is either applied at once or parked
// until commit. act_nxt is the value act_q takes at the coming edge, so a
// consumer reloading on the commit edge sees the parked value.
// Assumes commit is a single-cycle pulse from the count engine.
module tmr_shadow_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         defer,
    input  logic         commit,
    output logic [W-1:0] act_q,
    output logic [W-1:0] act_nxt
);
    logic [W-1:0] pend_q;
    logic         pend_v;

    // Next active value: direct write wins, then a pending commit.
    always_comb begin
        if (wr_en && !defer)
            act_nxt = wr_data;
        else if (commit && pend_v)
            act_nxt = pend_q;
        else
            act_nxt = act_q;
    end

    // Active value register.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_nxt;
    end

    // Parked value and its valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            pend_v <= 1'b0;
        end else if (wr_en && defer) begin
            pend_q <= wr_data;
            pend_v <= 1'b1;
        end else if (commit || wr_en) begin
            pend_v <= 1'b0;
        end
    end

    // R6, R7
    defer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && defer && !commit) |=> $stable(act_q));
endmodule

// File: rtl/tmr_count_engine.sv
// Counter, enable and chain-wait state. Decides when the count steps,
// reloads or times out. Assumes en_we pulses do not coincide with an
// unrelated interval write that the caller expects to be ignored.
module tmr_count_engine
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tmr_mode_e        mode,
    input  logic             cnt_up,
    input  logic             wait_trig,
    input  logic             en_we,
    input  logic             en_wd,
    input  logic             chain_trig,
    input  logic             ivl_load,
    input  logic [CNT_W-1:0] ivl_act,
    input  logic [CNT_W-1:0] ivl_nxt,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] free_q,
    output logic             start,
    output logic             step,
    output logic             timeout_ev
);
    logic             en_q;
    logic             go_q;
    logic             stop_req;
    logic             mode_ok;
    logic             at_term;
    logic [CNT_W-1:0] reload_val;

    assign start      = en_we & en_wd & ~en_q;
    assign stop_req   = en_we & ~en_wd;
    assign mode_ok    = (mode == MODE_ONESHOT) || (mode == MODE_PERIODIC);
    assign step       = go_q & mode_ok & ~stop_req;
    assign at_term    = cnt_up ? (cnt_q == ivl_act) : (cnt_q == '0);
    assign timeout_ev = step & at_term;
    assign reload_val = cnt_up ? '0 : ivl_nxt;

    // Enable and counting-active state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            go_q <= 1'b0;
        end else if (start) begin
            en_q <= 1'b1;
            go_q <= ~wait_trig;
        end else if (stop_req || (timeout_ev && mode == MODE_ONESHOT)) begin
            en_q <= 1'b0;
            go_q <= 1'b0;
        end else if (en_q && !go_q && chain_trig) begin
            go_q <= 1'b1;
        end
    end

    // Count register: load, reload, or step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start || ivl_load)
            cnt_q <= reload_val;
        else if (timeout_ev) begin
            if (mode == MODE_PERIODIC) cnt_q <= reload_val;
        end else if (step)
            cnt_q <= cnt_up ? cnt_q + 1'b1 : cnt_q - 1'b1;
    end

    // Free-running count of counting cycles since start.
    always_ff @(posedge clk) begin
        if (!rst_n)     free_q <= '0;
        else if (start) free_q <= '0;
        else if (step)  free_q <= free_q + 1'b1;
    end

    // R2
    down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cnt_up && cnt_q != '0 && !start && !ivl_load)
        |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));
    // R4
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_ev && mode == MODE_ONESHOT && !ivl_load)
        |=> (!go_q && cnt_q == $past(cnt_q)));
    // R5
    idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_ok && !start && !ivl_load) |=> $stable(cnt_q));
    // R10
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !go_q && !chain_trig && !ivl_load) |=> $stable(cnt_q));
    // R13
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !ivl_load) |=> ($stable(cnt_q) && !go_q));
endmodule

// File: rtl/tmr_event_gen.sv
// Registered event outputs (time-out, match, chain trigger) and the
// snapshot holding register behind the readable value.
// Assumes timeout_ev and step come from the count engine in the same cycle.
module tmr_event_gen #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             timeout_ev,
    input  logic             start,
    input  logic             snap_mode,
    input  logic             match_ie,
    input  logic             to_irq_dis,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] mat_act,
    input  logic [CNT_W-1:0] free_q,
    output logic             timeout_flag_q,
    output logic             match_flag_q,
    output logic             chain_trig_q,
    output logic [CNT_W-1:0] timer_val
);
    logic             match_ev;
    logic [CNT_W-1:0] snap_q;

    assign match_ev  = step & (cnt_q == mat_act);
    assign timer_val = snap_mode ? snap_q : cnt_q;

    // One-cycle event pulses, gated by their enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timeout_flag_q <= 1'b0;
            match_flag_q   <= 1'b0;
            chain_trig_q   <= 1'b0;
        end else begin
            timeout_flag_q <= timeout_ev & ~to_irq_dis;
            match_flag_q   <= match_ev & match_ie;
            chain_trig_q   <= timeout_ev | (match_ev & match_ie);
        end
    end

    // Snapshot of the free-running count at each time-out.
    always_ff @(posedge clk) begin
        if (!rst_n || start)
            snap_q <= '0;
        else if (timeout_ev && snap_mode)
            snap_q <= free_q;
    end

    // R12
    trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_ev |=> chain_trig_q);
    // R9
    to_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        to_irq_dis |=> !timeout_flag_q);
    // R8
    match_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_ie && !timeout_ev) |=> (!match_flag_q && !chain_trig_q));
    // R11
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_mode && !timeout_ev && !start) |=> $stable(snap_q));
endmodule

// File: rtl/gp_timer_core.sv
// Top of the timer core: two shadow registers (interval, match), the
// count engine and the event generator. Inputs are synchronous to clk.
module gp_timer_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_count_up,
    input  logic             cfg_ivl_defer,
    input  logic             cfg_match_defer,
    input  logic             cfg_wait_trig,
    input  logic             cfg_snap_en,
    input  logic             cfg_match_ie,
    input  logic             cfg_to_irq_dis,
    input  logic             en_we,
    input  logic             en_wd,
    input  logic             chain_trig_in,
    input  logic             ivl_we,
    input  logic [CNT_W-1:0] ivl_wd,
    input  logic             match_we,
    input  logic [CNT_W-1:0] match_wd,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] timer_val_o,
    output logic             timeout_flag_o,
    output logic             match_flag_o,
    output logic             chain_trig_o
);
    tmr_mode_e        mode_e;
    logic [CNT_W-1:0] ivl_act, ivl_nxt, mat_act, mat_nxt;
    logic [CNT_W-1:0] cnt_q, free_q;
    logic             start, step, timeout_ev, commit, snap_mode;

    assign mode_e    = tmr_mode_e'(cfg_mode);
    assign commit    = timeout_ev | start;
    assign snap_mode = cfg_snap_en && (mode_e == MODE_PERIODIC);
    assign count_o   = cnt_q;

    tmr_shadow_reg #(.W(CNT_W)) u_ivl_shadow (
        .clk(clk), .rst_n(rst_n), .wr_en(ivl_we), .wr_data(ivl_wd),
        .defer(cfg_ivl_defer), .commit(commit),
        .act_q(ivl_act), .act_nxt(ivl_nxt)
    );

    tmr_shadow_reg #(.W(CNT_W)) u_mat_shadow (
        .clk(clk), .rst_n(rst_n), .wr_en(match_we), .wr_data(match_wd),
        .defer(cfg_match_defer), .commit(commit),
        .act_q(mat_act), .act_nxt(mat_nxt)
    );

    tmr_count_engine #(.CNT_W(CNT_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .mode(mode_e), .cnt_up(cfg_count_up),
        .wait_trig(cfg_wait_trig), .en_we(en_we), .en_wd(en_wd),
        .chain_trig(chain_trig_in), .ivl_load(ivl_we & ~cfg_ivl_defer),
        .ivl_act(ivl_act), .ivl_nxt(ivl_nxt), .cnt_q(cnt_q), .free_q(free_q),
        .start(start), .step(step), .timeout_ev(timeout_ev)
    );

    tmr_event_gen #(.CNT_W(CNT_W)) u_events (
        .clk(clk), .rst_n(rst_n), .step(step), .timeout_ev(timeout_ev),
        .start(start), .snap_mode(snap_mode), .match_ie(cfg_match_ie),
        .to_irq_dis(cfg_to_irq_dis), .cnt_q(cnt_q), .mat_act(mat_act),
        .free_q(free_q), .timeout_flag_q(timeout_flag_o),
        .match_flag_q(match_flag_o), .chain_trig_q(chain_trig_o),
        .timer_val(timer_val_o)
    );

    // R7
    match_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_we && cfg_match_defer && !commit) |-> (mat_nxt == mat_act));
endmodule

// File: tb/gp_timer_core_bench.sv
`timescale 1ns/1ps
module gp_timer_core_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cfg_mode;
    logic        cfg_count_up, cfg_ivl_defer, cfg_match_defer, cfg_wait_trig;
    logic        cfg_snap_en, cfg_match_ie, cfg_to_irq_dis;
    logic        en_we, en_wd, chain_trig_in, ivl_we, match_we;
    logic [15:0] ivl_wd, match_wd;
    logic [15:0] count_o, timer_val_o;
    logic        timeout_flag_o, match_flag_o, chain_trig_o;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2 clk = ~clk;

    gp_timer_core u_gp_timer_core (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_count_up(cfg_count_up),
        .cfg_ivl_defer(cfg_ivl_defer), .cfg_match_defer(cfg_match_defer),
        .cfg_wait_trig(cfg_wait_trig), .cfg_snap_en(cfg_snap_en),
        .cfg_match_ie(cfg_match_ie), .cfg_to_irq_dis(cfg_to_irq_dis),
        .en_we(en_we), .en_wd(en_wd), .chain_trig_in(chain_trig_in),
        .ivl_we(ivl_we), .ivl_wd(ivl_wd), .match_we(match_we), .match_wd(match_wd),
        .count_o(count_o), .timer_val_o(timer_val_o), .timeout_flag_o(timeout_flag_o),
        .match_flag_o(match_flag_o), .chain_trig_o(chain_trig_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cfg_mode = 2'd0; cfg_count_up = 0; cfg_ivl_defer = 0; cfg_match_defer = 0;
        cfg_wait_trig = 0; cfg_snap_en = 0; cfg_match_ie = 0; cfg_to_irq_dis = 0;
        en_we = 0; en_wd = 0; chain_trig_in = 0; ivl_we = 0; match_we = 0;
        ivl_wd = '0; match_wd = '0;
        tick(); tick();
        check("R1 count", count_o, 0);
        check("R1 value", timer_val_o, 0);
        check("R1 flags", {timeout_flag_o, match_flag_o, chain_trig_o}, 0);
        rst_n = 1'b1;
        tick();
    endtask

    task automatic write_ivl(input int v);
        ivl_wd = 16'(v); ivl_we = 1; tick(); ivl_we = 0;
    endtask

    task automatic write_mat(input int v);
        match_wd = 16'(v); match_we = 1; tick(); match_we = 0;
    endtask

    task automatic set_enable(input logic v);
        en_wd = v; en_we = 1; tick(); en_we = 0;
    endtask

    task automatic t_down_periodic();
        do_reset();
        cfg_mode = 2'd2;
        write_ivl(3);
        check("R6 immediate load while idle", count_o, 3);
        set_enable(1);
        check("R2 start value", count_o, 3);
        tick(); check("R2 step", count_o, 2);
        tick(); tick(); check("R2 at zero", count_o, 0);
        check("R2 no early timeout", timeout_flag_o, 0);
        tick(); check("R2 reload", count_o, 3);
        check("R2 timeout flag", timeout_flag_o, 1);
        check("R12 trig at timeout", chain_trig_o, 1);
        tick(); check("R12 trig one cycle", chain_trig_o, 0);
        check("R2 after reload", count_o, 2);
    endtask

    task automatic t_up_oneshot();
        do_reset();
        cfg_mode = 2'd1; cfg_count_up = 1;
        write_ivl(2);
        check("R3 up load is zero", count_o, 0);
        set_enable(1);
        tick(); tick(); check("R3 rising", count_o, 2);
        tick(); check("R4 holds terminal", count_o, 2);
        check("R4 timeout flag", timeout_flag_o, 1);
        tick(); check("R4 single timeout", timeout_flag_o, 0);
        check("R12 oneshot trig ends", chain_trig_o, 0);
        tick(); check("R4 stopped", count_o, 2);
    endtask

    task automatic t_idle_modes();
        do_reset();
        cfg_mode = 2'd0;
        write_ivl(3);
        set_enable(1);
        tick(); tick(); tick();
        check("R5 mode0 frozen", count_o, 3);
        check("R5 mode0 no timeout", timeout_flag_o, 0);
        cfg_mode = 2'd3;
        tick(); tick();
        check("R5 mode3 frozen", count_o, 3);
        cfg_mode = 2'd2;
        tick(); check("R5 resumes in mode2", count_o, 2);
    endtask

    task automatic t_ivl_defer();
        do_reset();
        cfg_mode = 2'd2;
        write_ivl(3);
        set_enable(1);
        cfg_ivl_defer = 1;
        write_ivl(5);
        check("R6 deferred not loaded", count_o, 2);
        tick(); tick(); check("R6 old period", count_o, 0);
        tick(); check("R6 deferred reload", count_o, 5);
        check("R6 timeout", timeout_flag_o, 1);
        tick(); check("R6 new period", count_o, 4);
        cfg_ivl_defer = 0;
        write_ivl(7);
        check("R6 immediate while running", count_o, 7);
        tick(); check("R6 counts from new", count_o, 6);
    endtask

    task automatic t_match();
        do_reset();
        cfg_mode = 2'd2;
        write_ivl(3);
        write_mat(2);
        cfg_match_ie = 1;
        set_enable(1);
        tick(); check("R8 no match yet", match_flag_o, 0);
        tick(); check("R8 match flag", match_flag_o, 1);
        check("R8 match trig", chain_trig_o, 1);
        check("R7 immediate match count", count_o, 1);
        tick(); check("R8 match pulse ends", match_flag_o, 0);
        cfg_match_ie = 0;
        tick(); check("R2 reload in match test", count_o, 3);
        tick(); tick();
        check("R8 masked flag", match_flag_o, 0);
        check("R8 masked trig", chain_trig_o, 0);
        set_enable(0);
        check("R13 stop holds", count_o, 1);
        tick(); check("R13 stays stopped", count_o, 1);
        cfg_match_defer = 1;
        write_mat(1);
        cfg_match_ie = 1;
        set_enable(1);
        check("R7 restart value", count_o, 3);
        tick(); check("R7 pending applied", match_flag_o, 0);
        tick(); check("R7 old match gone", match_flag_o, 0);
        tick(); check("R7 new match", match_flag_o, 1);
    endtask

    task automatic t_irq_dis();
        do_reset();
        cfg_mode = 2'd2; cfg_to_irq_dis = 1;
        write_ivl(1);
        set_enable(1);
        tick(); tick();
        check("R9 reload", count_o, 1);
        check("R9 flag masked", timeout_flag_o, 0);
        check("R9 trig kept", chain_trig_o, 1);
    endtask

    task automatic t_wait();
        do_reset();
        cfg_mode = 2'd2; cfg_wait_trig = 1;
        write_ivl(3);
        set_enable(1);
        tick(); tick();
        check("R10 frozen before trigger", count_o, 3);
        chain_trig_in = 1; tick(); chain_trig_in = 0;
        check("R10 trigger edge", count_o, 3);
        tick(); check("R10 counting", count_o, 2);
    endtask

    task automatic t_snapshot();
        do_reset();
        cfg_mode = 2'd2; cfg_count_up = 1; cfg_snap_en = 1;
        write_ivl(3);
        set_enable(1);
        check("R11 initial snapshot", timer_val_o, 0);
        tick(); check("R11 not mirroring", timer_val_o, 0);
        tick(); tick(); tick();
        check("R3 wrap to zero", count_o, 0);
        check("R11 first snapshot", timer_val_o, 3);
        tick(); tick(); tick(); tick();
        check("R11 second snapshot", timer_val_o, 7);
        cfg_snap_en = 0;
        tick(); check("R11 live value", timer_val_o, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_down_periodic();
        t_up_oneshot();
        t_idle_modes();
        t_ivl_defer();
        t_match();
        t_irq_dis();
        t_wait();
        t_snapshot();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule